// File: doc/BRIEF.md
# Quadrature Encoder Step Decoder

This block turns the two raw phase lines of an incremental shaft encoder into a count-enable strobe and a direction flag. An external binary counter consumes them. Both lines are brought into the system clock domain through a short chain of flip-flops. The block then compares each new two-bit phase sample with the one taken a cycle earlier. A move of one position along the Gray sequence is a step. Its direction follows from which neighbour the new state is.

A rate selector sets the resolution to one, two or four counts per full electrical cycle. Every step produces a strobe and its opposite step produces the opposite strobe. Contact bounce and jitter back and forth across an edge therefore cancel out in the counter. The only condition is that the clock samples faster than the shortest time between edges. The outputs are plain control pins and carry no valid/ready handshake. The counter is assumed to accept a strobe on every cycle, so no back-pressure exists.

Top module: `quad_step_decoder`

## Requirements
- R1: While `rst` is high, and after it falls with both encoder lines held steady at any level, `cnt_en` stays low. Reset loads every sampling flop with the present line levels.
- R2: A single change on a raw line produces its `cnt_en` pulse on the (SYNC_STAGES+1)-th rising clock edge after the change. With the default of 2 stages, that is the third edge.
- R3: The phase state is {A,B}. The forward order is 00, 01, 11, 10, 00. With `rate` = 2'b10, every single-bit step gives exactly one pulse, so a full cycle gives four.
- R4: A forward step pulses with `cnt_up` = 1. A reverse step pulses with `cnt_up` = 0.
- R5: With `rate` = 2'b01, only steps in which A changes are counted, two per cycle. Steps in which only B changes give no pulse.
- R6: With `rate` = 2'b00, only the steps 01→11 (up) and 11→01 (down) are counted. These are the A edges while B is high, one per cycle.
- R7: A sample in which A and B both changed is an illegal jump and gives no pulse.
- R8: Bouncing back and forth across one edge, with each level held at least one clock cycle, leaves the net count (ups minus downs) unchanged.
- R9: Every counted step gives a pulse one cycle wide. `cnt_up` is low whenever `cnt_en` is low.
- R10: `rate` = 2'b11 behaves like 2'b10 (four counts per cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shortest edge spacing |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Raw phase A line, asynchronous |
| enc_b | input | 1 | Raw phase B line, asynchronous |
| rate | input | 2 | Counts per cycle: 00 one, 01 two, 1x four |
| cnt_en | output | 1 | One-cycle count strobe for the external counter |
| cnt_up | output | 1 | Direction for the strobe: 1 up, 0 down |

## Verification
The bench goes after bursts of bounce of random length and hold time. A design that failed to cancel reverse steps would drift its net count there. It also drives simultaneous changes on both lines, which a decoder that keyed on XOR alone would count. At the single and double rates it moves B alone and checks that no pulses appear; a filter that leaked these would show a pulse total above the expected one. Reset is released with both lines high to catch a design that clears its samplers to zero and then emits a false step. The latency of one edge is measured exactly, so a missing or extra synchronizer stage shows up as a shifted pulse.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int AB_W = 2;

  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X2  = 2'b01,
    RATE_X4  = 2'b10,
    RATE_X4B = 2'b11
  } rate_t;

  // Classified transition between two consecutive phase samples
  typedef struct packed {
    logic legal;   // exactly one Gray position moved
    logic up;      // moved forward along 00,01,11,10
    logic a_moved; // channel A toggled
    logic b_high;  // B was high before and after the move
  } step_t;

  // Position of a {A,B} sample in the forward Gray order
  function automatic logic [1:0] phase_of(input logic [1:0] ab);
    case (ab)
      2'b00:   phase_of = 2'd0;
      2'b01:   phase_of = 2'd1;
      2'b11:   phase_of = 2'd2;
      default: phase_of = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // Reset preloads the present level so release creates no edge
  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{din}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [AB_W-1:0] seed_ab,
  input  logic [AB_W-1:0] cur_ab,
  output logic [AB_W-1:0] prev_ab,
  output step_t           step
);

  logic [1:0] ph_cur;
  logic [1:0] ph_prev;
  logic [1:0] ph_diff;

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= seed_ab;
    else     prev_ab <= cur_ab;
  end

  always_comb begin
    ph_cur       = phase_of(cur_ab);
    ph_prev      = phase_of(prev_ab);
    ph_diff      = ph_cur - ph_prev;
    step.legal   = (ph_diff == 2'd1) || (ph_diff == 2'd3);
    step.up      = (ph_diff == 2'd1);
    step.a_moved = cur_ab[1] ^ prev_ab[1];
    step.b_high  = cur_ab[0] & prev_ab[0];
  end

endmodule

// File: rtl/qdec_rate_filter.sv
module qdec_rate_filter
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate,
  input  step_t      step,
  output logic       cnt_en,
  output logic       cnt_up
);

  logic take;

  always_comb begin
    case (rate_t'(rate))
      RATE_X1: take = step.legal & step.a_moved & step.b_high;
      RATE_X2: take = step.legal & step.a_moved;
      default: take = step.legal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en <= 1'b0;
      cnt_up <= 1'b0;
    end else begin
      cnt_en <= take;
      cnt_up <= take & step.up;
    end
  end

  // R3 / R10: four-count rate strobes on every legal step
  a_r3_every_step: assert property (@(posedge clk) disable iff (rst)
    (rate[1] && step.legal) |=> cnt_en);

  // R4: reverse steps never report up
  a_r4_reverse_down: assert property (@(posedge clk) disable iff (rst)
    (step.legal && !step.up) |=> !cnt_up);

  // R5: two-count rate ignores steps without an A edge
  a_r5_b_only_ignored: assert property (@(posedge clk) disable iff (rst)
    (rate == 2'b01 && !step.a_moved) |=> !cnt_en);

  // R6: one-count rate ignores A edges with B low
  a_r6_b_low_ignored: assert property (@(posedge clk) disable iff (rst)
    (rate == 2'b00 && !step.b_high) |=> !cnt_en);

  // R9: direction idle when no strobe
  a_r9_up_idle_low: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !cnt_up);

endmodule

// File: rtl/quad_step_decoder.sv
module quad_step_decoder
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic [1:0] rate,
  output logic       cnt_en,
  output logic       cnt_up
);

  logic [AB_W-1:0] raw_ab;
  logic [AB_W-1:0] cur_ab;
  logic [AB_W-1:0] prev_ab;
  step_t           step;

  assign raw_ab = {enc_a, enc_b};

  for (genvar i = 0; i < AB_W; i++) begin : g_sync
    qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_ab[i]),
      .dout (cur_ab[i])
    );
  end

  qdec_step u_step (
    .clk     (clk),
    .rst     (rst),
    .seed_ab (raw_ab),
    .cur_ab  (cur_ab),
    .prev_ab (prev_ab),
    .step    (step)
  );

  qdec_rate_filter u_filter (
    .clk    (clk),
    .rst    (rst),
    .rate   (rate),
    .step   (step),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up)
  );

  // R7: a double-bit jump between samples is never counted
  a_r7_jump_dropped: assert property (@(posedge clk) disable iff (rst)
    ((cur_ab ^ prev_ab) == 2'b11) |=> !cnt_en);

endmodule

// File: tb/tb_quad_step_decoder.sv
`timescale 1ns/100ps
module tb_quad_step_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a = 1'b0;
  logic       b = 1'b0;
  logic [1:0] rate = 2'b10;
  logic       cnt_en;
  logic       cnt_up;

  int checks = 0;
  int bad = 0;
  int pulses = 0;
  int net = 0;
  int idle_up_errs = 0;
  int exp_net = 0;
  int exp_pulses = 0;
  logic [1:0] cur_ab = 2'b00;

  always #2.5 clk = ~clk;

  quad_step_decoder dut (
    .clk(clk), .rst(rst), .enc_a(a), .enc_b(b),
    .rate(rate), .cnt_en(cnt_en), .cnt_up(cnt_up)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cnt_en) begin
        pulses++;
        net += cnt_up ? 1 : -1;
      end else if (cnt_up) begin
        idle_up_errs++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ph(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  // Expected counter change from the requirements
  function automatic int exp_delta(input logic [1:0] p, input logic [1:0] n, input logic [1:0] r);
    int d;
    d = (ph(n) - ph(p)) & 3;
    if (d == 0 || d == 2) return 0;
    if (r == 2'b00) begin
      if (p == 2'b01 && n == 2'b11) return 1;
      if (p == 2'b11 && n == 2'b01) return -1;
      return 0;
    end
    if (r == 2'b01 && p[1] == n[1]) return 0;
    return (d == 1) ? 1 : -1;
  endfunction

  task automatic move(input logic [1:0] ab, input int hold);
    int dl;
    @(negedge clk);
    dl = exp_delta(cur_ab, ab, rate);
    exp_net += dl;
    if (dl != 0) exp_pulses++;
    cur_ab = ab;
    a = ab[1];
    b = ab[0];
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic drain_and_clear();
    repeat (6) @(negedge clk);
    pulses = 0; net = 0; exp_net = 0; exp_pulses = 0;
  endtask

  task automatic settle_check(input string req);
    repeat (6) @(negedge clk);
    chk(net == exp_net, req, net, exp_net);
    chk(pulses == exp_pulses, req, pulses, exp_pulses);
    pulses = 0; net = 0; exp_net = 0; exp_pulses = 0;
  endtask

  task automatic full_cycle(input bit fwd);
    for (int k = 1; k <= 4; k++)
      move(ab_of(ph(cur_ab) + (fwd ? 1 : 3)), 3);
  endtask

  task automatic random_run(input logic [1:0] r, input int n, input string req);
    int sel, cnt;
    logic [1:0] home, nb;
    rate = r;
    drain_and_clear();
    for (int i = 0; i < n; i++) begin
      sel = $urandom_range(0, 9);
      if (sel <= 3) move(ab_of(ph(cur_ab) + 1), $urandom_range(1, 4));
      else if (sel <= 6) move(ab_of(ph(cur_ab) + 3), $urandom_range(1, 4));
      else if (sel == 7) move(cur_ab ^ 2'b11, $urandom_range(1, 4));
      else begin
        home = cur_ab;
        nb = ab_of(ph(cur_ab) + (($urandom_range(0, 1) == 1) ? 1 : 3));
        cnt = $urandom_range(1, 5);
        for (int k = 0; k < cnt; k++) begin
          move(nb, $urandom_range(1, 3));
          move(home, $urandom_range(1, 3));
        end
      end
    end
    settle_check(req);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset with both lines high, then release without a move
    a = 1'b1; b = 1'b1; cur_ab = 2'b11;
    repeat (3) @(negedge clk);
    chk(cnt_en == 1'b0, "R1 during reset", int'(cnt_en), 0);
    rst = 1'b0;
    pulses = 0; net = 0;
    repeat (8) @(negedge clk);
    chk(pulses == 0, "R1 no count after release", pulses, 0);
    chk(cnt_en == 1'b0 && cnt_up == 1'b0, "R1 outputs idle", int'({cnt_en, cnt_up}), 0);

    // R2: latency of the first strobe, state 11 -> 01 is reverse in x4
    rate = 2'b10;
    @(negedge clk); a = 1'b0; cur_ab = 2'b01;
    @(negedge clk);
    chk(cnt_en == 1'b0, "R2 edge1 quiet", int'(cnt_en), 0);
    @(negedge clk);
    chk(cnt_en == 1'b0, "R2 edge2 quiet", int'(cnt_en), 0);
    @(negedge clk);
    chk(cnt_en == 1'b1 && cnt_up == 1'b0, "R2 edge3 strobe down (R4)", int'({cnt_en, cnt_up}), 2);
    @(negedge clk);
    chk(cnt_en == 1'b0, "R9 strobe one cycle wide", int'(cnt_en), 0);
    drain_and_clear();

    // R3 / R4: full cycles at x4
    full_cycle(1'b1); settle_check("R3 x4 forward cycle");
    full_cycle(1'b0); settle_check("R4 x4 reverse cycle");
    // R5: x2
    rate = 2'b01; full_cycle(1'b1); settle_check("R5 x2 forward cycle");
    // R6: x1
    rate = 2'b00; full_cycle(1'b1); settle_check("R6 x1 forward cycle");
    full_cycle(1'b0); settle_check("R6 x1 reverse cycle");
    // R10: rate 11 as x4
    rate = 2'b11; full_cycle(1'b1); settle_check("R10 rate 11 cycle");

    // R7: illegal jump at x4
    rate = 2'b10;
    move(cur_ab ^ 2'b11, 4);
    settle_check("R7 illegal jump");

    // R8: bounce of A between 01 and 11 at x1
    rate = 2'b00;
    while (cur_ab != 2'b01) move(ab_of(ph(cur_ab) + 1), 3);
    drain_and_clear();
    for (int k = 0; k < 5; k++) begin
      move(2'b11, 1);
      move(2'b01, 2);
    end
    settle_check("R8 bounce x1");

    // Random mixes per rate
    random_run(2'b10, 300, "R3 R8 random x4");
    random_run(2'b01, 300, "R5 R8 random x2");
    random_run(2'b00, 300, "R6 R8 random x1");

    chk(idle_up_errs == 0, "R9 up low while idle", idle_up_errs, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule